// File: doc/BRIEF.md
# Dual Timer/Event Counter with Capture

The block holds two up-counting 8-bit timers for a small microcontroller peripheral set. Each timer advances either on a tick from its own prescaler, which divides an incoming clock-enable strobe by 2, 4, 8, 32, 128, 512 or 2048, or on rising edges of an external event pin. In compare mode the count is checked against a data register at every tick. When they are equal, the count returns to zero and the timer's interrupt line pulses for one cycle. This gives an interrupt period of (data + 1) ticks. For example, a divide-by-32 tick from a 4 MHz strobe with data 124 yields 1 ms.

In capture mode the counter runs freely and wraps. A rising edge on the timer's capture pin copies the live count into a read-only capture register. Timer 0 can absorb timer 1 to form one 16-bit counter. The low half supplies the tick and the high half counts the low half's carries. The compare then uses both data registers, and a capture loads both capture registers. Software reaches everything through a small register bus with 3-bit addresses and combinational read data.

Each timer has a control state machine with four states: `ST_IDLE` (stopped), `ST_MATCH` (counting with compare-and-clear), `ST_FREE` (free-running with capture) and `ST_SLAVE` (timer 1 only, acting as the upper half of the chained counter). The transitions are as follows:
- Raising start enters `ST_MATCH`, or `ST_FREE` when capture mode is set.
- Dropping start returns the timer to `ST_IDLE`.
- Toggling capture mode while running moves directly between `ST_MATCH` and `ST_FREE`.
- Setting the chain bit sends timer 1 from any state to `ST_SLAVE`.
- Clearing the chain bit sends timer 1 from `ST_SLAVE` to `ST_IDLE`. It then follows its own start bit.

Top module: `evtmr_pair`

## Requirements
- R1: After reset every register reads zero and both interrupt lines are low.
- R2: Clock-select codes 0..6 pick ratios 2, 4, 8, 32, 128, 512, 2048 of clk_en pulses. In compare mode, consecutive interrupts are ratio*(data+1) clk_en pulses apart.
- R3: In compare mode, a tick that finds count equal to data sets the count to 0 and pulses that timer's irq bit high for exactly one cycle. The count reads 0 while irq is high.
- R4: Clock-select code 7 counts each rising edge of the timer's evt_pin, after a two-flop synchronizer.
- R5: While the start bit (ctrl bit 3) is 0, the count holds its value whatever the pins do.
- R6: Writing ctrl with bit 4 set zeroes the count and the prescaler at that write's clock edge. Bit 4 always reads back 0.
- R7: With capture mode (ctrl bit 5) set, the counter wraps from 255 to 0 with no match and no interrupt. A rising edge on cap_pin copies the current count into the capture register, which otherwise holds its value.
- R8: With the chain bit (timer 0 ctrl bit 6) set, the two timers form a 16-bit counter: timer 0 is the low byte and timer 1 is the high byte. The compare uses {data1,data0}, a match clears both halves and pulses irq[0] only, and irq[1] stays low.
- R9: In chained capture mode, a rising edge on cap_pin[0] loads the low count into capture 0 and the high count into capture 1.
- R10: bus_addr[2] selects the timer. bus_addr[1:0] selects the register: 0 = ctrl, 1 = data, 2 = count (read-only), 3 = capture (read-only). ctrl bits [2:0] hold the clock select. Bit 7 reads 0, and bit 6 reads 0 on timer 1. Writes to count or capture have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Clock-enable strobe that feeds the prescalers |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| evt_pin | input | 2 | External event inputs, one per timer |
| cap_pin | input | 2 | Capture trigger inputs, one per timer |
| irq | output | 2 | One-cycle interrupt pulses, one per timer |

## Verification
The hardest state to reach from the ports is the chained 16-bit match. Reaching it needs the low byte to carry into the high byte and then meet a compare value above 255, and with internal ticks that would take thousands of cycles at an unknown phase. The bench therefore selects external-event counting and drives evt_pin with exactly counted pulses. This walks the 16-bit count to 0x0100, then to the compare value and past it, reading both halves at each stop. The same technique brings the capture-mode counter through its 255-to-0 wrap, which confirms that no match clears it on the way.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MATCH = 2'd1,
        ST_FREE  = 2'd2,
        ST_SLAVE = 2'd3
    } tmr_state_e;

    localparam logic [2:0] SEL_EXT = 3'd7;

    localparam logic [1:0] REG_CTRL  = 2'd0;
    localparam logic [1:0] REG_DATA  = 2'd1;
    localparam logic [1:0] REG_COUNT = 2'd2;
    localparam logic [1:0] REG_CAPT  = 2'd3;

    localparam int CB_START = 3;
    localparam int CB_CLEAR = 4;
    localparam int CB_CAPM  = 5;
    localparam int CB_CHAIN = 6;

    typedef struct packed {
        logic       chain;
        logic       capm;
        logic       start;
        logic [2:0] sel;
    } tmr_ctrl_t;

    // log2 of the prescale ratio for each internal clock-select code
    function automatic logic [3:0] sel_log2(input logic [2:0] sel);
        logic [3:0] r;
        case (sel)
            3'd0:    r = 4'd1;
            3'd1:    r = 4'd2;
            3'd2:    r = 4'd3;
            3'd3:    r = 4'd5;
            3'd4:    r = 4'd7;
            3'd5:    r = 4'd9;
            3'd6:    r = 4'd11;
            default: r = 4'd1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-1:0], pin};
        end
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int PRE_W = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_en,
    input  logic       hold,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic [3:0]       shamt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (hold) begin
            pre_q <= '0;
        end else if (clk_en) begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    always_comb begin
        shamt = sel_log2(sel);
        mask  = (PRE_W'(1) << shamt) - PRE_W'(1);
        tick  = clk_en & ~hold & ((pre_q & mask) == mask);
    end
endmodule

// File: rtl/tmr_fsm.sv
module tmr_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic capm,
    input  logic slave,
    output logic cnt_en,
    output logic cmp_en,
    output logic cap_en,
    output logic is_slave
);
    tmr_state_e state_q;
    tmr_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (slave)              state_d = ST_SLAVE;
                else if (start && capm) state_d = ST_FREE;
                else if (start)         state_d = ST_MATCH;
            end
            ST_MATCH: begin
                if (slave)       state_d = ST_SLAVE;
                else if (!start) state_d = ST_IDLE;
                else if (capm)   state_d = ST_FREE;
            end
            ST_FREE: begin
                if (slave)       state_d = ST_SLAVE;
                else if (!start) state_d = ST_IDLE;
                else if (!capm)  state_d = ST_MATCH;
            end
            ST_SLAVE: begin
                if (!slave)      state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        cnt_en   = 1'b0;
        cmp_en   = 1'b0;
        cap_en   = 1'b0;
        is_slave = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_MATCH: begin cnt_en = 1'b1; cmp_en = 1'b1; end
            ST_FREE:  begin cnt_en = 1'b1; cap_en = 1'b1; end
            ST_SLAVE: is_slave = 1'b1;
        endcase
    end
endmodule

// File: rtl/evtmr_pair.sv
module evtmr_pair
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PRE_W       = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic [2:0]       bus_addr,
    input  logic             bus_we,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic [1:0]       evt_pin,
    input  logic [1:0]       cap_pin,
    output logic [1:0]       irq
);
    localparam int NUM   = 2;
    localparam int CTL_W = $bits(tmr_ctrl_t) + 1;

    tmr_ctrl_t        ctrl_q [NUM];
    logic [CNT_W-1:0] data_q [NUM];
    logic [CNT_W-1:0] cnt_q  [NUM];
    logic [CNT_W-1:0] cnt_d  [NUM];
    logic [CNT_W-1:0] cap_q  [NUM];

    logic [NUM-1:0] ctrl_wr, data_wr, clr_wr;
    logic [NUM-1:0] evt_rise, cap_rise, pre_tick, tick, hit, cap_hit;
    logic [NUM-1:0] cnt_en, cmp_en, cap_en, is_slave;
    logic [NUM-1:0] irq_q;
    logic           chained, eq0, carry0;

    // bus write decode
    always_comb begin
        for (int i = 0; i < NUM; i++) begin
            ctrl_wr[i] = bus_we && (bus_addr[2] == 1'(i)) && (bus_addr[1:0] == REG_CTRL);
            data_wr[i] = bus_we && (bus_addr[2] == 1'(i)) && (bus_addr[1:0] == REG_DATA);
            clr_wr[i]  = ctrl_wr[i] && bus_wdata[CB_CLEAR];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) begin
                ctrl_q[i] <= '0;
                data_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM; i++) begin
                if (ctrl_wr[i]) begin
                    ctrl_q[i].chain <= (i == 0) ? bus_wdata[CB_CHAIN] : 1'b0;
                    ctrl_q[i].capm  <= bus_wdata[CB_CAPM];
                    ctrl_q[i].start <= bus_wdata[CB_START];
                    ctrl_q[i].sel   <= bus_wdata[2:0];
                end
                if (data_wr[i]) begin
                    data_q[i] <= bus_wdata;
                end
            end
        end
    end

    // per-timer synchronizers, prescaler and control state machine
    for (genvar g = 0; g < NUM; g++) begin : g_tmr
        tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_evt (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (evt_pin[g]),
            .rise  (evt_rise[g])
        );
        tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_cap (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (cap_pin[g]),
            .rise  (cap_rise[g])
        );
        tmr_prescale #(.PRE_W(PRE_W)) u_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .clk_en (clk_en),
            .hold   (~cnt_en[g] | clr_wr[g]),
            .sel    (ctrl_q[g].sel),
            .tick   (pre_tick[g])
        );
        tmr_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (ctrl_q[g].start),
            .capm     (ctrl_q[g].capm),
            .slave    ((g != 0) && ctrl_q[0].chain),
            .cnt_en   (cnt_en[g]),
            .cmp_en   (cmp_en[g]),
            .cap_en   (cap_en[g]),
            .is_slave (is_slave[g])
        );
    end

    // count next-state, match and chaining
    always_comb begin
        chained = is_slave[1];
        for (int i = 0; i < NUM; i++) begin
            tick[i] = cnt_en[i] & ((ctrl_q[i].sel == SEL_EXT) ? evt_rise[i] : pre_tick[i]);
            cap_hit[i] = cap_en[i] & cap_rise[i];
        end
        eq0    = chained ? ({cnt_q[1], cnt_q[0]} == {data_q[1], data_q[0]})
                         : (cnt_q[0] == data_q[0]);
        hit[0] = tick[0] & cmp_en[0] & eq0;
        hit[1] = tick[1] & cmp_en[1] & (cnt_q[1] == data_q[1]);
        carry0 = tick[0] & (cnt_q[0] == {CNT_W{1'b1}});

        if (clr_wr[0] || hit[0])  cnt_d[0] = '0;
        else if (tick[0])         cnt_d[0] = cnt_q[0] + CNT_W'(1);
        else                      cnt_d[0] = cnt_q[0];

        if (chained) begin
            if (clr_wr[0] || clr_wr[1] || hit[0]) cnt_d[1] = '0;
            else if (carry0)                      cnt_d[1] = cnt_q[1] + CNT_W'(1);
            else                                  cnt_d[1] = cnt_q[1];
        end else begin
            if (clr_wr[1] || hit[1])  cnt_d[1] = '0;
            else if (tick[1])         cnt_d[1] = cnt_q[1] + CNT_W'(1);
            else                      cnt_d[1] = cnt_q[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) begin
                cnt_q[i] <= '0;
                cap_q[i] <= '0;
            end
            irq_q <= '0;
        end else begin
            for (int i = 0; i < NUM; i++) begin
                cnt_q[i] <= cnt_d[i];
            end
            if (cap_hit[0]) begin
                cap_q[0] <= cnt_q[0];
                if (chained) cap_q[1] <= cnt_q[1];
            end
            if (cap_hit[1]) begin
                cap_q[1] <= cnt_q[1];
            end
            irq_q <= hit;
        end
    end

    assign irq = irq_q;

    // combinational read mux
    always_comb begin
        logic t;
        t = bus_addr[2];
        unique case (bus_addr[1:0])
            REG_CTRL:  bus_rdata = CNT_W'({1'b0, ctrl_q[t].chain, ctrl_q[t].capm, 1'b0,
                                          ctrl_q[t].start, ctrl_q[t].sel});
            REG_DATA:  bus_rdata = data_q[t];
            REG_COUNT: bus_rdata = cnt_q[t];
            REG_CAPT:  bus_rdata = cap_q[t];
        endcase
    end

    if (CTL_W > CNT_W) begin : g_width_check
        initial $display("evtmr_pair: CNT_W too narrow for ctrl");
    end
endmodule

// File: rtl/evtmr_pair_chk.sv
module evtmr_pair_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       irq,
    input logic [CNT_W-1:0] cnt0,
    input logic [CNT_W-1:0] cap0,
    input logic             clr_wr0,
    input logic             cnt_en0,
    input logic             cap_en0,
    input logic             cap_rise0,
    input logic             slave1
);
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |=> !irq[0]);                                             // R3
    AST_IRQ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |-> (cnt0 == '0));                                        // R3
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr0 |=> (cnt0 == '0));                                       // R6
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en0 && !clr_wr0) |=> $stable(cnt0));                       // R5
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_en0 && cap_rise0) |=> $stable(cap0));                      // R7
    AST_FREE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en0 |=> !irq[0]);                                            // R7
    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        slave1 |=> !irq[1]);                                             // R8
endmodule

bind evtmr_pair evtmr_pair_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .cnt0      (cnt_q[0]),
    .cap0      (cap_q[0]),
    .clr_wr0   (clr_wr[0]),
    .cnt_en0   (cnt_en[0]),
    .cap_en0   (cap_en[0]),
    .cap_rise0 (cap_rise[0]),
    .slave1    (is_slave[1])
);

// File: tb/evtmr_pair_tb_top.sv
module evtmr_pair_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] evt_pin = '0;
    logic [1:0] cap_pin = '0;
    logic [1:0] irq;

    int  checks = 0;
    int  failures = 0;
    int  irq0_n = 0;
    int  irq1_n = 0;
    logic en_half = 1'b0;
    logic phase = 1'b0;
    logic done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) phase <= ~phase;
    assign clk_en = en_half ? phase : 1'b1;

    always @(negedge clk) begin
        if (irq[0]) irq0_n++;
        if (irq[1]) irq1_n++;
    end

    evtmr_pair dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_pin(evt_pin), .cap_pin(cap_pin), .irq(irq)
    );

    // {sel, data, clk_en divisor, expected irq spacing in clk cycles}
    localparam logic [31:0] VEC [9] = '{
        {4'd0, 8'd3, 4'd1, 16'd8},
        {4'd1, 8'd2, 4'd1, 16'd12},
        {4'd2, 8'd0, 4'd1, 16'd8},
        {4'd3, 8'd1, 4'd1, 16'd64},
        {4'd4, 8'd0, 4'd1, 16'd128},
        {4'd5, 8'd1, 4'd1, 16'd1024},
        {4'd6, 8'd0, 4'd1, 16'd2048},
        {4'd0, 8'd4, 4'd2, 16'd20},
        {4'd3, 8'd2, 4'd2, 16'd192}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        @(negedge clk);
        bus_addr = a;
        #1 d = int'(bus_rdata);
    endtask

    // which: 0 evt0, 1 evt1, 2 cap0, 3 cap1
    task automatic pulse(input int which, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (which < 2) evt_pin[which] = 1'b1; else cap_pin[which-2] = 1'b1;
            repeat (2) @(negedge clk);
            if (which < 2) evt_pin[which] = 1'b0; else cap_pin[which-2] = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_irq0(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!irq[0] && cyc < 5000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog all-R actual=timeout expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v, n0, n1, cyc;
        repeat (3) @(negedge clk);
        chk("R1", "irq in reset", int'(irq), 0);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1", $sformatf("reg %0d after reset", a), v, 0);
        end

        // R10 control field layout and read-only registers
        wr(3'd0, 8'hB5);
        rd(3'd0, v); chk("R10", "ctrl0 readback bit7/clear dropped", v, 8'h25);
        wr(3'd4, 8'h47);
        rd(3'd4, v); chk("R10", "ctrl1 has no chain bit", v, 8'h07);
        wr(3'd0, 8'h10); wr(3'd4, 8'h10);

        // R2 / R3 table of prescaler ratios
        for (int e = 0; e < 9; e++) begin
            wr(3'd0, 8'h10);
            wr(3'd1, VEC[e][27:20]);
            en_half = (VEC[e][19:16] == 4'd2);
            wr(3'd0, {5'b00001, VEC[e][30:28]});
            wait_irq0(cyc);
            wait_irq0(cyc);
            chk("R2", $sformatf("irq spacing vec %0d", e), cyc, int'(VEC[e][15:0]));
            bus_addr = 3'd2;
            #1 chk("R3", $sformatf("count zero at irq vec %0d", e), int'(bus_rdata), 0);
        end
        wr(3'd0, 8'h10);
        en_half = 1'b0;

        // R4 external event counting
        wr(3'd1, 8'd200);
        wr(3'd0, 8'h1F);
        pulse(0, 5);
        rd(3'd2, v); chk("R4", "count after 5 events", v, 5);
        pulse(1, 3);
        rd(3'd2, v); chk("R4", "other timer pin ignored", v, 5);

        // R6 clear
        wr(3'd0, 8'h1F);
        rd(3'd2, v); chk("R6", "count after clear", v, 0);
        rd(3'd0, v); chk("R6", "clear bit reads zero", v, 8'h0F);

        // R5 stop holds
        pulse(0, 2);
        wr(3'd0, 8'h07);
        pulse(0, 3);
        rd(3'd2, v); chk("R5", "count held while stopped", v, 2);

        // R10 count is read-only
        wr(3'd2, 8'h55);
        rd(3'd2, v); chk("R10", "write to count ignored", v, 2);

        // R3 match with events
        wr(3'd1, 8'd2);
        wr(3'd0, 8'h1F);
        n0 = irq0_n;
        pulse(0, 2);
        rd(3'd2, v); chk("R3", "count before match", v, 2);
        chk("R3", "no irq before match", irq0_n, n0);
        pulse(0, 1);
        rd(3'd2, v); chk("R3", "count cleared at match", v, 0);
        chk("R3", "one irq at match", irq0_n, n0 + 1);

        // R7 capture mode
        wr(3'd1, 8'd1);
        wr(3'd0, 8'h3F);
        n0 = irq0_n;
        pulse(0, 3);
        rd(3'd2, v); chk("R7", "free-run passes data", v, 3);
        pulse(2, 1);
        rd(3'd3, v); chk("R7", "capture value", v, 3);
        pulse(0, 253);
        rd(3'd2, v); chk("R7", "wrap to zero", v, 0);
        rd(3'd3, v); chk("R7", "capture held", v, 3);
        chk("R7", "no irq in capture mode", irq0_n, n0);

        // R8 chained 16-bit compare
        wr(3'd4, 8'h10);
        wr(3'd5, 8'd1);
        wr(3'd1, 8'd2);
        wr(3'd0, 8'h5F);
        n0 = irq0_n; n1 = irq1_n;
        pulse(0, 256);
        rd(3'd2, v); chk("R8", "low byte after 256", v, 0);
        rd(3'd6, v); chk("R8", "high byte after 256", v, 1);
        pulse(0, 2);
        rd(3'd2, v); chk("R8", "low byte at 0x0102", v, 2);
        chk("R8", "no early irq", irq0_n, n0);
        pulse(0, 1);
        rd(3'd2, v); chk("R8", "low cleared at match", v, 0);
        rd(3'd6, v); chk("R8", "high cleared at match", v, 0);
        chk("R8", "irq0 at 16-bit match", irq0_n, n0 + 1);
        chk("R8", "irq1 quiet when chained", irq1_n, n1);

        // R9 chained capture
        wr(3'd4, 8'h10);
        wr(3'd0, 8'h7F);
        pulse(0, 300);
        pulse(2, 1);
        rd(3'd3, v); chk("R9", "capture low", v, 8'h2C);
        rd(3'd7, v); chk("R9", "capture high", v, 8'h01);

        // R3 timer 1 on its own
        wr(3'd0, 8'h10);
        wr(3'd5, 8'd1);
        wr(3'd4, 8'h1F);
        n0 = irq0_n; n1 = irq1_n;
        pulse(1, 2);
        rd(3'd6, v); chk("R3", "timer1 count cleared", v, 0);
        chk("R3", "timer1 irq", irq1_n, n1 + 1);
        chk("R3", "timer0 irq unaffected", irq0_n, n0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule